// File: doc/BRIEF.md
# Converter Result Offset Shifter

This block takes a signed result from an analog-to-digital converter and recasts it as an unsigned count. The converter resolution can be set at run time to any width from 12 to 18 bits. Each resolution has a full scale of 2^(n-1)-1 counts. When the range is centered, a zero input lands at half scale. For sensors that carry a large positive offset, one of three further range shifts can be selected. Each one moves the zero point toward the top of the count range, so more of that range is left for the signal. Negative offsets are not handled here: the input polarity is swapped upstream instead.

Each result also gets a linearity flag. The flag is raised when the count falls outside the band from one tenth to nine tenths of full scale.

The block has two control states. In `ST_IDLE` no fresh result is being presented. In `ST_EMIT` the output registers hold a result that was captured on the previous edge, and the output valid strobe is high. The transition `IDLE->EMIT` and the self-loop `EMIT->EMIT` are taken on any cycle with an input valid. The transitions `EMIT->IDLE` and `IDLE->IDLE` are taken on any cycle without one. Reset forces `ST_IDLE`.

Top module: `adc_offset_shifter`

## Requirements
- R1: A sample presented with `in_valid` high is captured on that rising edge. Its count and flag appear on the outputs, and `out_valid` is high, during the next cycle.
- R2: After a cycle with `in_valid` low, `out_valid` is low in the next cycle, and `out_count` and `out_over` keep their previous values.
- R3: While `rst_n` is low, `out_count`, `out_over` and `out_valid` are all 0.
- R4: `res_sel` value k in 0..6 selects a resolution of n = 12+k bits. The values 7 and above select 18 bits. The full scale is FS = 2^(n-1)-1.
- R5: Bit n-1 of `in_sample` is the sign of the n-bit two's complement result. Bits n and above are ignored.
- R6: With `shift_sel` = 0 (centered), count = x + (2^(n-2)-1), where x is the signed n-bit sample.
- R7: `shift_sel` = 1 adds a further 2^(n-3) to the count (+25%). `shift_sel` = 2 adds a further 3*2^(n-4) (+37.5%). `shift_sel` = 3 adds a further 7*2^(n-5) (+43.75%). At 16 bits, a zero sample therefore gives 24575, 28671 and 30719.
- R8: A sum below 0 saturates to a count of 0.
- R9: A sum above FS saturates to a count of FS.
- R10: `out_over` is 1 exactly when count < floor(FS/10) or count > floor(9*FS/10). At 16 bits, 3276 and 29490 are inside the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | MAX_RES (18) | Signed converter result, sign at bit n-1 |
| res_sel | input | SEL_W (3) | Resolution code, n = 12 + code, clamped to 18 |
| shift_sel | input | 2 | Range shift: 0 centered, 1 +25%, 2 +37.5%, 3 +43.75% |
| out_count | output | MAX_RES-1 (17) | Registered unsigned count |
| out_over | output | 1 | Count lies outside the linear band |
| out_valid | output | 1 | A fresh result is on the outputs |

## Verification
If the phase register were stuck or mis-sequenced, the effect would show in the very next cycle. `out_valid` would either miss a captured sample or stay high through an idle cycle. Errors in the resolution decode, the sign extension or the offset arithmetic corrupt `out_count` in the cycle right after capture. Centered zero inputs and clipped extremes expose these errors most clearly. A wrong window table shows up only for counts close to the 10% and 90% edges, so the bench probes those edges one count on each side.

// File: rtl/aos_pkg.sv
package aos_pkg;

    typedef enum logic [1:0] {
        SHIFT_MID   = 2'd0,
        SHIFT_P250  = 2'd1,
        SHIFT_P375  = 2'd2,
        SHIFT_P4375 = 2'd3
    } shift_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } phase_e;

    // Lower edge of the linear band for an n-bit converter.
    function automatic int band_lo(input int n);
        return ((1 << (n - 1)) - 1) / 10;
    endfunction

    // Upper edge of the linear band for an n-bit converter.
    function automatic int band_hi(input int n);
        return (((1 << (n - 1)) - 1) * 9) / 10;
    endfunction

endpackage

// File: rtl/aos_res_decode.sv
module aos_res_decode #(
    parameter int MIN_RES = 12,
    parameter int MAX_RES = 18,
    parameter int SEL_W   = 3,
    parameter int NW      = 5
) (
    input  logic [SEL_W-1:0] res_sel,
    output logic [SEL_W-1:0] res_idx,
    output logic [NW-1:0]    res_bits
);
    localparam int SPAN = MAX_RES - MIN_RES;

    // Codes above the widest setting clamp to it.
    always_comb begin
        if (int'(res_sel) > SPAN) begin
            res_idx = SEL_W'(SPAN);
        end else begin
            res_idx = res_sel;
        end
        res_bits = NW'(MIN_RES) + NW'(res_idx);
    end

endmodule

// File: rtl/aos_range_map.sv
module aos_range_map
    import aos_pkg::*;
#(
    parameter int MAX_RES = 18,
    parameter int NW      = 5
) (
    input  logic [MAX_RES-1:0] sample,
    input  logic [NW-1:0]      res_bits,
    input  shift_e             shift_sel,
    output logic [MAX_RES-2:0] count
);
    localparam int CNT_W = MAX_RES - 1;
    localparam int SUM_W = MAX_RES + 2;

    logic [NW-1:0]                 drop;
    logic signed [MAX_RES-1:0]     aligned;
    logic signed [MAX_RES-1:0]     sext;
    logic signed [SUM_W-1:0]       full_scale;
    logic signed [SUM_W-1:0]       mid;
    logic signed [SUM_W-1:0]       eighth;
    logic signed [SUM_W-1:0]       offs;
    logic signed [SUM_W-1:0]       sum;

    always_comb begin
        // Sign extend from bit res_bits-1, discarding the bits above it.
        drop    = NW'(MAX_RES) - res_bits;
        aligned = $signed(sample << drop);
        sext    = aligned >>> drop;

        full_scale = $signed((SUM_W'(1) << (res_bits - NW'(1))) - SUM_W'(1));
        mid        = $signed((SUM_W'(1) << (res_bits - NW'(2))) - SUM_W'(1));
        eighth     = $signed(SUM_W'(1) << (res_bits - NW'(3)));

        unique case (shift_sel)
            SHIFT_MID:   offs = '0;
            SHIFT_P250:  offs = eighth;
            SHIFT_P375:  offs = eighth + (eighth >>> 1);
            SHIFT_P4375: offs = eighth + (eighth >>> 1) + (eighth >>> 2);
            default:     offs = '0;
        endcase

        sum = SUM_W'(sext) + mid + offs;

        if (sum < 0) begin
            count = '0;
        end else if (sum > full_scale) begin
            count = full_scale[CNT_W-1:0];
        end else begin
            count = sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/aos_lin_window.sv
module aos_lin_window
    import aos_pkg::*;
#(
    parameter int MIN_RES = 12,
    parameter int MAX_RES = 18,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   res_idx,
    input  logic [MAX_RES-2:0] count,
    output logic               outside
);
    localparam int CNT_W = MAX_RES - 1;
    localparam int ROWS  = 1 << SEL_W;

    logic [CNT_W-1:0] lo_tab [ROWS];
    logic [CNT_W-1:0] hi_tab [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        localparam int N = (MIN_RES + g > MAX_RES) ? MAX_RES : MIN_RES + g;
        assign lo_tab[g] = CNT_W'(band_lo(N));
        assign hi_tab[g] = CNT_W'(band_hi(N));
    end

    always_comb begin
        outside = (count < lo_tab[res_idx]) || (count > hi_tab[res_idx]);
    end

endmodule

// File: rtl/adc_offset_shifter.sv
module adc_offset_shifter
    import aos_pkg::*;
#(
    parameter int MIN_RES = 12,
    parameter int MAX_RES = 18,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [MAX_RES-1:0] in_sample,
    input  logic [SEL_W-1:0]   res_sel,
    input  logic [1:0]         shift_sel,
    output logic [MAX_RES-2:0] out_count,
    output logic               out_over,
    output logic               out_valid
);
    localparam int CNT_W = MAX_RES - 1;
    localparam int NW    = $clog2(MAX_RES + 1);

    logic [SEL_W-1:0] res_idx;
    logic [NW-1:0]    res_bits;
    logic [CNT_W-1:0] mapped;
    logic             outside;
    phase_e           phase_q;
    phase_e           phase_d;

    aos_res_decode #(
        .MIN_RES (MIN_RES),
        .MAX_RES (MAX_RES),
        .SEL_W   (SEL_W),
        .NW      (NW)
    ) u_decode (
        .res_sel  (res_sel),
        .res_idx  (res_idx),
        .res_bits (res_bits)
    );

    aos_range_map #(
        .MAX_RES (MAX_RES),
        .NW      (NW)
    ) u_map (
        .sample    (in_sample),
        .res_bits  (res_bits),
        .shift_sel (shift_e'(shift_sel)),
        .count     (mapped)
    );

    aos_lin_window #(
        .MIN_RES (MIN_RES),
        .MAX_RES (MAX_RES),
        .SEL_W   (SEL_W)
    ) u_window (
        .res_idx (res_idx),
        .count   (mapped),
        .outside (outside)
    );

    // Next phase.
    always_comb begin
        unique case (phase_q)
            ST_IDLE: phase_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: phase_d = in_valid ? ST_EMIT : ST_IDLE;
            default: phase_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= ST_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Result registers, loaded on every accepted sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_count <= '0;
            out_over  <= 1'b0;
        end else if (in_valid) begin
            out_count <= mapped;
            out_over  <= outside;
        end
    end

    assign out_valid = (phase_q == ST_EMIT);

endmodule

// File: rtl/aos_checker.sv
module aos_checker #(
    parameter int MIN_RES = 12,
    parameter int MAX_RES = 18,
    parameter int SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [MAX_RES-1:0] in_sample,
    input logic [SEL_W-1:0]   res_sel,
    input logic [1:0]         shift_sel,
    input logic [MAX_RES-2:0] out_count,
    input logic               out_over,
    input logic               out_valid
);
    int unsigned chk_n;
    int unsigned chk_fs;
    int unsigned chk_mid;

    always_comb begin
        chk_n   = (int'(res_sel) > MAX_RES - MIN_RES) ? MAX_RES : MIN_RES + int'(res_sel);
        chk_fs  = (32'd1 << (chk_n - 1)) - 1;
        chk_mid = chk_fs / 2;
    end

    AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_count) && $stable(out_over)); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (out_count == '0) && !out_over && !out_valid); // R3

    AST_WITHIN_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> int'(out_count) <= int'($past(chk_fs))); // R9

    AST_ZERO_CENTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sample == '0 && shift_sel == 2'd0)
        |=> int'(out_count) == int'($past(chk_mid))); // R6

    AST_BAND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_over ==
            ((int'(out_count) < int'($past(chk_fs)) / 10) ||
             (int'(out_count) > (int'($past(chk_fs)) * 9) / 10))); // R10

endmodule

bind adc_offset_shifter aos_checker #(
    .MIN_RES (MIN_RES),
    .MAX_RES (MAX_RES),
    .SEL_W   (SEL_W)
) u_aos_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .res_sel   (res_sel),
    .shift_sel (shift_sel),
    .out_count (out_count),
    .out_over  (out_over),
    .out_valid (out_valid)
);

// File: tb/tb_adc_offset_shifter.sv
module tb_adc_offset_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_RES    = 18;
    localparam int SEL_W      = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [MAX_RES-1:0] in_sample = '0;
    logic [SEL_W-1:0]   res_sel = '0;
    logic [1:0]         shift_sel = '0;
    logic [MAX_RES-2:0] out_count;
    logic               out_over;
    logic               out_valid;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_offset_shifter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .res_sel   (res_sel),
        .shift_sel (shift_sel),
        .out_count (out_count),
        .out_over  (out_over),
        .out_valid (out_valid)
    );

    function automatic int ref_count(input logic [MAX_RES-1:0] s, input int rs, input int sh);
        int n;
        int fs;
        int v;
        int off;
        int c;
        n  = (rs > 6) ? 18 : 12 + rs;
        fs = (1 << (n - 1)) - 1;
        v  = int'(s) & ((1 << n) - 1);
        if (v >= (1 << (n - 1))) v = v - (1 << n);
        case (sh)
            1:       off = (1 << n) / 8;
            2:       off = 3 * (1 << n) / 16;
            3:       off = 7 * (1 << n) / 32;
            default: off = 0;
        endcase
        c = v + fs / 2 + off;
        if (c < 0) c = 0;
        if (c > fs) c = fs;
        return c;
    endfunction

    function automatic bit ref_flag(input int c, input int rs);
        int n;
        int fs;
        n  = (rs > 6) ? 18 : 12 + rs;
        fs = (1 << (n - 1)) - 1;
        return (c < fs / 10) || (c > (fs * 9) / 10);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Called at a negative edge: presents one sample, checks it one cycle later.
    task automatic apply(input string req, input logic [MAX_RES-1:0] s, input int rs, input int sh);
        int c;
        c = ref_count(s, rs, sh);
        in_valid  = 1'b1;
        in_sample = s;
        res_sel   = SEL_W'(rs);
        shift_sel = 2'(sh);
        @(negedge clk);
        check({req, " count"}, int'(out_count), c);
        check({req, " flag"}, int'(out_over), int'(ref_flag(c, rs)));
        check({req, " valid (R1)"}, int'(out_valid), 1);
    endtask

    // Called at a negative edge: an idle cycle with a disturbed sample.
    task automatic idle_cycle();
        int held_c;
        int held_f;
        held_c    = int'(out_count);
        held_f    = int'(out_over);
        in_valid  = 1'b0;
        in_sample = MAX_RES'($urandom);
        shift_sel = 2'($urandom);
        @(negedge clk);
        check("R2 valid low", int'(out_valid), 0);
        check("R2 count held", int'(out_count), held_c);
        check("R2 flag held", int'(out_over), held_f);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R3 count", int'(out_count), 0);
        check("R3 flag", int'(out_over), 0);
        check("R3 valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 / R7: zero sample at 16 bits under each shift.
        apply("R6 zero centered", '0, 4, 0);
        check("R6 value", int'(out_count), 16383);
        apply("R7 zero +25%", '0, 4, 1);
        check("R7 value", int'(out_count), 24575);
        apply("R7 zero +37.5%", '0, 4, 2);
        check("R7 value", int'(out_count), 28671);
        apply("R7 zero +43.75%", '0, 4, 3);
        check("R7 value", int'(out_count), 30719);
        idle_cycle();

        // R8 / R9: saturation at both ends.
        apply("R8 floor", MAX_RES'(-32768), 4, 0);
        check("R8 value", int'(out_count), 0);
        apply("R9 ceiling", MAX_RES'(32767), 4, 3);
        check("R9 value", int'(out_count), 32767);
        apply("R9 ceiling 12b", MAX_RES'(2047), 0, 3);
        check("R9 value 12b", int'(out_count), 2047);

        // R10: band edges at 16 bits, one count either side.
        apply("R10 at lo", MAX_RES'(3276 - 16383), 4, 0);
        check("R10 lo inside", int'(out_over), 0);
        apply("R10 below lo", MAX_RES'(3275 - 16383), 4, 0);
        check("R10 lo outside", int'(out_over), 1);
        apply("R10 at hi", MAX_RES'(29490 - 16383), 4, 0);
        check("R10 hi inside", int'(out_over), 0);
        apply("R10 above hi", MAX_RES'(29491 - 16383), 4, 0);
        check("R10 hi outside", int'(out_over), 1);

        // R4: codes beyond 6 act as 18 bits; R5: bits above n ignored.
        apply("R4 code 7", MAX_RES'(100), 7, 1);
        check("R4 value", int'(out_count), 100 + 65535 + 32768);
        apply("R5 upper bits", 18'h3F800, 0, 0);
        check("R5 value", int'(out_count), 1023 - 2048 < 0 ? 0 : 1023 - 2048);
        apply("R5 sign bit", 18'h20400, 0, 2);
        idle_cycle();

        // Random traffic with idle gaps.
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 4) == 0) begin
                idle_cycle();
            end else begin
                apply("R7 random", MAX_RES'($urandom), int'($urandom_range(0, 7)),
                      int'($urandom_range(0, 3)));
            end
        end
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule